// File: doc/BRIEF.md
# Load/Store Memory Access Datapath

This block is the single-cycle memory-access slice of a 32-bit processor that keeps arithmetic and memory access in separate instructions. Each cycle it takes one instruction word with a valid strobe. It reads a base register and adds the sign-extended 16-bit literal to it, which gives a byte address for main memory. A load writes the returned word into the destination register. A store sends the destination register's value out as write data and leaves the register file unchanged.

The register file holds 32 words and has two combinational read ports and one write port that is clocked. Register 31 always reads as zero. Using it as the base turns the literal into an absolute address. Main memory is reached through a plain interface: address, write data and write enable go out, and read data comes back in the same cycle.

Top module: `ldst_datapath`

## Requirements
- R1: Instruction fields are: opcode in bits 31:26, destination/source register rc in bits 25:21, base register ra in bits 20:16, literal in bits 15:0, and a second register index rb in bits 15:11. Opcode 6'b011000 is a load and 6'b011001 is a store.
- R2: mem_addr_o always equals the contents of register ra plus the 16-bit literal sign-extended to 32 bits, combinationally in the same cycle.
- R3: When valid_i is high with a load, mem_rdata_i is written into register rc on the next rising clock edge, and later instructions see the new value.
- R4: When valid_i is high with a store, mem_wdata_o carries the contents of register rc and mem_we_o is high in that cycle only.
- R5: A store never writes the register file.
- R6: Register 31 reads as zero, and a load that targets register 31 leaves it at zero.
- R7: With register 31 as base, the literal alone is the address: 0x1008 gives 0x00001008, and a literal with bit 15 set gives 0xFFFF_xxxx.
- R8: mem_we_o is high only for a valid store. A low valid_i or an unrecognised opcode causes no register write and no memory write.
- R9: In every cycle that is not a valid store, the second read port is addressed by rb, and mem_wdata_o shows the contents of register rb.
- R10: An active-low asynchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction is valid this cycle |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_wdata_o | output | 32 | Store data (second read port value) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Word returned by memory |

## Verification
The checker verifies on every cycle the rules that depend on the current cycle alone:
- write enable appears only for a valid store, and always appears for one;
- a store never raises the register write;
- nothing is written while valid_i is low;
- an R31 base produces exactly the sign-extended literal;
- a store from R31 sends zero.

Some behaviour only shows up over a sequence of instructions, and the scoreboard scenarios cover it. Examples are load-after-store data, a discarded load into R31, and rejected opcodes that leave a register untouched. Negative offsets from a non-zero base and the rb readout during loads also need these scenarios.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int INSTR_W   = 32;
  localparam int OPC_W     = 6;
  localparam int REG_IDX_W = 5;
  localparam int LIT_W     = 16;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b011000;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b011001;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2
  } mem_op_e;

  typedef struct packed {
    logic [OPC_W-1:0]     opcode;
    logic [REG_IDX_W-1:0] rc;
    logic [REG_IDX_W-1:0] ra;
    logic [REG_IDX_W-1:0] rb;
    logic [LIT_W-1:0]     lit;
  } instr_fields_t;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               valid_i,
  output instr_fields_t      fields_o,
  output mem_op_e            op_o
);
  always_comb begin
    fields_o.opcode = instr_i[31:26];
    fields_o.rc     = instr_i[25:21];
    fields_o.ra     = instr_i[20:16];
    fields_o.rb     = instr_i[15:11];
    fields_o.lit    = instr_i[15:0];
  end

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      unique case (fields_o.opcode)
        OPC_LOAD:  op_o = OP_LOAD;
        OPC_STORE: op_o = OP_STORE;
        default:   op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int ZERO_REG = NUM_REGS - 1,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     raddr1_i,
  output logic [DATA_W-1:0] rdata1_o,
  input  logic [AW-1:0]     raddr2_i,
  output logic [DATA_W-1:0] rdata2_o,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == ZERO_REG) begin : g_zero
      assign regs_q[r] = '0;  // hardwired, writes dropped
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          regs_q[r] <= '0;
        else if (we_i && waddr_i == AW'(r))
          regs_q[r] <= wdata_i;
      end
    end
  end

  assign rdata1_o = regs_q[raddr1_i];
  assign rdata2_o = regs_q[raddr2_i];
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 16
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [LIT_W-1:0]  lit_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [DATA_W-1:0] lit_sext;

  assign lit_sext = {{(DATA_W-LIT_W){lit_i[LIT_W-1]}}, lit_i};
  // same adder an add-constant op would use
  assign addr_o   = base_i + lit_sext;
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               valid_i,
  output logic [DATA_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_we_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  localparam int AW = $clog2(NUM_REGS);

  instr_fields_t     fld;
  mem_op_e           op;
  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] port2_val;
  logic [AW-1:0]     port2_addr;
  logic              rf_we;
  logic [AW-1:0]     rf_waddr;

  ldst_decode u_dec (
    .instr_i  (instr_i),
    .valid_i  (valid_i),
    .fields_o (fld),
    .op_o     (op)
  );

  // store reads its data through the rc field
  assign port2_addr = (op == OP_STORE) ? AW'(fld.rc) : AW'(fld.rb);
  assign rf_we      = (op == OP_LOAD);
  assign rf_waddr   = AW'(fld.rc);

  ldst_regfile #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raddr1_i (AW'(fld.ra)),
    .rdata1_o (base_val),
    .raddr2_i (port2_addr),
    .rdata2_o (port2_val),
    .we_i     (rf_we),
    .waddr_i  (rf_waddr),
    .wdata_i  (mem_rdata_i)
  );

  ldst_agen #(
    .DATA_W (DATA_W),
    .LIT_W  (LIT_W)
  ) u_agen (
    .base_i (base_val),
    .lit_i  (fld.lit),
    .addr_o (mem_addr_o)
  );

  assign mem_wdata_o = port2_val;
  assign mem_we_o    = (op == OP_STORE);
endmodule

// File: rtl/ldst_datapath_chk.sv
module ldst_datapath_chk
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic               valid_i,
  input logic [DATA_W-1:0]  mem_addr_o,
  input logic [DATA_W-1:0]  mem_wdata_o,
  input logic               mem_we_o,
  input logic               rf_we
);
  logic is_ld, is_st, base_zero;
  assign is_ld     = valid_i && instr_i[31:26] == OPC_LOAD;
  assign is_st     = valid_i && instr_i[31:26] == OPC_STORE;
  assign base_zero = instr_i[20:16] == 5'd31;

  assert_we_only_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> is_st);

  assert_we_on_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_st |-> mem_we_o);

  assert_store_no_rf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_st |-> !rf_we);

  assert_load_writes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ld |-> rf_we);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!rf_we && !mem_we_o));

  assert_abs_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_zero |-> mem_addr_o == {{(DATA_W-16){instr_i[15]}}, instr_i[15:0]});

  assert_zero_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_st && instr_i[25:21] == 5'd31) |-> mem_wdata_o == '0);
endmodule

bind ldst_datapath ldst_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .valid_i     (valid_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .rf_we       (rf_we)
);

// File: tb/sim_ldst_datapath.sv
module sim_ldst_datapath;
  localparam logic [5:0] LD = 6'b011000;
  localparam logic [5:0] ST = 6'b011001;
  localparam int MW = 256;

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [31:0] wdata;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        valid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  logic [31:0] mem [MW];
  logic [31:0] exp_mem [MW];
  logic [31:0] exp_rf [32];
  exp_t        exp_q [$];
  exp_t        cur;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ldst_datapath u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .instr_i     (instr),
    .valid_i     (valid),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [31:0] init_word(int i);
    return (i == 8) ? 32'h0000_0100 : (32'hA500_0000 | i);
  endfunction

  // behavioural word memory, index = address bits 9:2
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) mem[i] <= init_word(i);
    end else if (mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr[9:2]];

  function automatic void check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  // driver: issue one instruction, predict the outputs from the model
  task automatic issue(input logic v, input logic [31:0] ins, input string tag);
    exp_t e;
    logic [4:0] rc, ra, rb;
    logic [31:0] addr;
    logic is_ld, is_st;
    @(posedge clk);
    #1;
    valid = v;
    instr = ins;
    rc = ins[25:21]; ra = ins[20:16]; rb = ins[15:11];
    is_ld = v && ins[31:26] == LD;
    is_st = v && ins[31:26] == ST;
    addr = exp_rf[ra] + {{16{ins[15]}}, ins[15:0]};
    e.addr  = addr;
    e.we    = is_st;
    e.wdata = is_st ? exp_rf[rc] : exp_rf[rb];
    e.tag   = tag;
    exp_q.push_back(e);
    if (is_ld && rc != 5'd31) exp_rf[rc] = exp_mem[addr[9:2]];
    if (is_st) exp_mem[addr[9:2]] = exp_rf[rc];
  endtask

  function automatic logic [31:0] mk(logic [5:0] op, int rc, int ra, logic [15:0] lit);
    return {op, 5'(rc), 5'(ra), lit};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      check(cur.tag, "addr", mem_addr, cur.addr);
      check(cur.tag, "we", {31'b0, mem_we}, {31'b0, cur.we});
      check(cur.tag, "wdata", mem_wdata, cur.wdata);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_rf[i] = '0;
    for (int i = 0; i < MW; i++) exp_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: registers cleared by reset
    issue(1, mk(ST, 7, 5, 16'h0000), "R10");
    issue(1, mk(LD, 1, 31, 16'h1008), "R7");          // absolute 0x1008
    issue(1, mk(LD, 2, 31, 16'h0004), "R1");
    issue(1, mk(LD, 4, 31, 16'h0020), "R3");          // r4 = 0x100
    issue(1, mk(ST, 1, 4, 16'h0008), "R4");           // store r1 at 0x108
    issue(1, mk(LD, 5, 4, 16'h0008), "R3");           // load back
    issue(1, mk(ST, 5, 4, 16'hFFFC), "R2");           // negative offset 0xFC
    issue(1, mk(LD, 31, 31, 16'h0020), "R6");         // discarded
    issue(1, mk(ST, 31, 4, 16'h0000), "R6");          // r31 still zero
    issue(1, mk(LD, 6, 31, 16'h8000), "R7");          // 0xFFFF8000
    issue(0, mk(LD, 8, 31, 16'h0004), "R8");          // not valid
    issue(1, mk(ST, 8, 31, 16'h0010), "R8");          // r8 still zero
    issue(1, mk(6'b010000, 9, 31, 16'h0004), "R8");   // unknown opcode
    issue(1, mk(ST, 9, 31, 16'h0014), "R8");
    issue(1, mk(LD, 10, 31, 16'h0800), "R9");         // rb = r1 on port 2
    issue(0, mk(ST, 2, 31, 16'h1000), "R9");          // invalid store shows rb
    issue(1, mk(ST, 1, 4, 16'h0010), "R4");           // back-to-back stores
    issue(1, mk(ST, 2, 4, 16'h0014), "R4");
    issue(1, mk(LD, 11, 4, 16'h0014), "R3");
    issue(1, mk(ST, 11, 31, 16'h0018), "R3");
    issue(0, 32'h0, "R8");
    repeat (3) @(posedge clk);
    #2;
    // R4: memory contents after all stores
    for (int i = 0; i < MW; i++) check("R4", "mem", mem[i], exp_mem[i]);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule